// File: doc/BRIEF.md
# DMA Channel Control Register File

This block holds the software-visible control state of a single-channel bus-master DMA engine inside a storage controller. It offers eight word-addressed 32-bit registers. Software loads a transfer count, a memory address and a descriptor-list pointer into three start registers, then writes a command. The command register carries a 2-bit operation field and several mode bits. A start operation copies each start register into its working counterpart in one clock edge, clears the status flags and enables the transfer engine. An idle operation disables the engine. An abort operation sends a cancel pulse to the request in progress. A blast operation only produces its own pulse.

The status register collects sticky event flags that the transfer logic raises through a set vector. A mode input selects how software clears the error, abort and done flags. With the mode low, writing ones clears them. With the mode high, status writes are ignored and a read strobe clears them on the following edge, after the value has been returned. The SCSI-interrupt bit is never stored: it mirrors the core interrupt input on every status read. Reset is synchronous and partial. Some fields return to defined values, and others keep their contents so that state survives a controller reset.

Top module: `dma_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following values are loaded: working address (index 4) becomes 0xFFFFFFFF; working descriptor address (index 7) becomes 0xFFFFFFFD; working count (index 3) bits [15:0] become 0; command (index 0) bits 0, 1, 2, 4, 5, 6 and 7 become 0; status bits 1 to 5 become 0; `xfer_en` becomes 0.
- R2: A write updates only command (index 0), start count (index 1), start address (index 2) and start descriptor address (index 6), and each of these reads back the written word. Writes to working count (3), working address (4) and working descriptor address (7) leave them unchanged.
- R3: A command write decodes wdata[1:0]: 3 is start, 0 is idle, 2 is abort, 1 is blast. In the same cycle as the write strobe, start raises `start_pulse`, abort raises `abort_pulse` and blast raises `blast_pulse`, with at most one of these high. `xfer_en` is 1 from the edge of a start write and 0 from the edge of an idle write. Blast and abort leave `xfer_en` unchanged.
- R4: At the edge of a start write, working count takes start count, working address takes start address, and working descriptor address takes start descriptor address.
- R5: At the edge of a start write, status bits 0 to 5 are cleared, unless the same bit is being set in that cycle.
- R6: Status bits 0 (power-down), 1 (error), 2 (abort), 3 (done) and 5 (blast complete) are set at the edge where the matching bit of `flag_set` is 1, and they hold until cleared. A set wins over any clear in the same cycle. `flag_set[4]` has no effect.
- R7: With `rd_clr_mode` = 0, a write to status (index 5) clears status bits 1, 2 and 3 wherever wdata has a one. Bits 0 and 5 are not affected.
- R8: With `rd_clr_mode` = 1, status writes are ignored. A read strobe (`rd_en`) on index 5 returns the current value, and status bits 1, 2 and 3 are then 0 from the next edge. Bits 0 and 5 are kept.
- R9: Status read data bit 4 equals `core_irq` in the same cycle, and bit 4 is never held in state. Status read data bits 31 to 6 are 0.
- R10: Reset keeps status bit 0, command bits 3 and 8 to 31, working count bits [31:16], and the start count, start address and start descriptor address registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used for clear-on-read) |
| addr | input | 3 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rd_clr_mode | input | 1 | 1: status cleared by read; 0: cleared by write-one |
| core_irq | input | 1 | SCSI core interrupt flag, shown in status bit 4 |
| flag_set | input | 6 | Per-bit status set requests from the transfer logic |
| xfer_en | output | 1 | Transfer engine enable level |
| start_pulse | output | 1 | Start command strobe |
| abort_pulse | output | 1 | Cancel request toward the active transfer |
| blast_pulse | output | 1 | Blast command strobe |

## Verification
The bench builds the block with its default parameters: the working count clears its low 16 bits at reset, and the working address and descriptor reset values are 0xFFFFFFFF and 0xFFFFFFFD. With a 16-bit clear width, a count with nonzero upper and lower halves shows which half survives a reset. The distinct reset values of the two working pointers make a swapped pointer visible. Because `rdata` is combinational and the clear-on-read happens only under `rd_en`, the bench can observe status without a read strobe. This lets it separate the value returned by a strobed read from the value left afterwards.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int DW   = 32;
  localparam int AW   = 3;
  localparam int NREG = 1 << AW;
  localparam int SW   = 6;

  localparam int IX_CMD  = 0;
  localparam int IX_SCNT = 1;
  localparam int IX_SADR = 2;
  localparam int IX_WCNT = 3;
  localparam int IX_WADR = 4;
  localparam int IX_STAT = 5;
  localparam int IX_SDSC = 6;
  localparam int IX_WDSC = 7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  // status flag positions
  localparam int SB_PWDN  = 0;
  localparam int SB_IRQ   = 4;

  localparam logic [SW-1:0] STAT_STORE = 6'h2F;  // bit 4 is never stored
  localparam logic [SW-1:0] STAT_CLRBL = 6'h0E;  // error, abort, done
  localparam logic [SW-1:0] STAT_RSTM  = 6'h3E;  // cleared by reset
  localparam logic [DW-1:0] CMD_RSTM   = 32'h0000_00F7;

  function automatic bit f_is_work(int i);
    return (i == IX_WCNT) || (i == IX_WADR) || (i == IX_WDSC);
  endfunction

  function automatic int f_src_idx(int i);
    case (i)
      IX_WCNT: return IX_SCNT;
      IX_WADR: return IX_SADR;
      IX_WDSC: return IX_SDSC;
      default: return i;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_rst_mask(int i, int cnt_clr_w);
    logic [DW-1:0] m;
    m = '0;
    case (i)
      IX_CMD:  m = CMD_RSTM;
      IX_WCNT: for (int b = 0; b < DW; b++) m[b] = (b < cnt_clr_w);
      IX_WADR: m = '1;
      IX_WDSC: m = '1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] f_rst_val(int i, logic [DW-1:0] wa,
                                              logic [DW-1:0] wd);
    if (i == IX_WADR) return wa;
    if (i == IX_WDSC) return wd;
    return '0;
  endfunction

  function automatic logic [SW-1:0] f_stat_w1c(logic [SW-1:0] s,
                                               logic [SW-1:0] w);
    return s & ~(w & STAT_CLRBL);
  endfunction

  function automatic logic [DW-1:0] f_stat_view(logic [SW-1:0] s, logic irq);
    logic [DW-1:0] v;
    v = '0;
    v[SW-1:0] = s & STAT_STORE;
    v[SB_IRQ] = irq;
    return v;
  endfunction
endpackage

// File: rtl/dma_hold_reg.sv
module dma_hold_reg #(
  parameter int           W        = 32,
  parameter logic [W-1:0] RST_MASK = '0,
  parameter logic [W-1:0] RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // bits outside RST_MASK keep their value through reset
  always_ff @(posedge clk) begin
    if (!rst_n) q <= (q & ~RST_MASK) | (RST_VAL & RST_MASK);
    else if (ld) q <= d;
  end
endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [1:0] op,
  output logic       start_p,
  output logic       abort_p,
  output logic       blast_p,
  output logic       xfer_en
);
  dma_op_e op_e;
  logic    idle_p;

  always_comb begin
    op_e    = dma_op_e'(op);
    start_p = cmd_wr && (op_e == OP_START);
    abort_p = cmd_wr && (op_e == OP_ABORT);
    blast_p = cmd_wr && (op_e == OP_BLAST);
    idle_p  = cmd_wr && (op_e == OP_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       xfer_en <= 1'b0;
    else if (start_p) xfer_en <= 1'b1;
    else if (idle_p)  xfer_en <= 1'b0;
  end
endmodule

// File: rtl/dma_stat_flags.sv
module dma_stat_flags
  import dma_ctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] flag_set,
  input  logic          start_clr,
  input  logic          wr_stat,
  input  logic [SW-1:0] wval,
  input  logic          rd_stat,
  input  logic          rd_clr_mode,
  output logic [SW-1:0] stat_q
);
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (start_clr) nxt = '0;
    if (wr_stat && !rd_clr_mode) nxt = f_stat_w1c(nxt, wval);
    if (rd_stat && rd_clr_mode)  nxt = nxt & ~STAT_CLRBL;
    nxt = nxt | (flag_set & STAT_STORE);  // set has priority
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= stat_q & ~STAT_RSTM;
    else        stat_q <= nxt;
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
#(
  parameter int          CNT_CLR_W = 16,
  parameter logic [31:0] WADDR_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] WDESC_RST = 32'hFFFF_FFFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rd_clr_mode,
  input  logic          core_irq,
  input  logic [SW-1:0] flag_set,
  output logic          xfer_en,
  output logic          start_pulse,
  output logic          abort_pulse,
  output logic          blast_pulse
);
  logic [DW-1:0]   reg_q [NREG];
  logic [NREG-1:0] wr_sel;
  logic [SW-1:0]   stat_q;
  logic            rd_stat;

  // named internal views for the checker
  logic [DW-1:0] work_cnt, start_cnt, work_addr;

  always_comb begin
    for (int k = 0; k < NREG; k++)
      wr_sel[k] = wr_en && rst_n && (addr == AW'(k));
  end

  assign rd_stat = rd_en && rst_n && (addr == AW'(IX_STAT));

  dma_cmd_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (wr_sel[IX_CMD]),
    .op      (wdata[1:0]),
    .start_p (start_pulse),
    .abort_p (abort_pulse),
    .blast_p (blast_pulse),
    .xfer_en (xfer_en)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IX_STAT) begin : g_stat
      dma_stat_flags u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_set    (flag_set),
        .start_clr   (start_pulse),
        .wr_stat     (wr_sel[i]),
        .wval        (wdata[SW-1:0]),
        .rd_stat     (rd_stat),
        .rd_clr_mode (rd_clr_mode),
        .stat_q      (stat_q)
      );
      assign reg_q[i] = {{(DW-SW){1'b0}}, stat_q};
    end else begin : g_hold
      localparam bit IS_WORK = f_is_work(i);
      localparam int SRC     = f_src_idx(i);
      logic          ld;
      logic [DW-1:0] d;
      assign ld = IS_WORK ? start_pulse : wr_sel[i];
      assign d  = IS_WORK ? reg_q[SRC] : wdata;
      dma_hold_reg #(
        .W        (DW),
        .RST_MASK (f_rst_mask(i, CNT_CLR_W)),
        .RST_VAL  (f_rst_val(i, WADDR_RST, WDESC_RST))
      ) u_r (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .d     (d),
        .q     (reg_q[i])
      );
    end
  end

  assign work_cnt  = reg_q[IX_WCNT];
  assign start_cnt = reg_q[IX_SCNT];
  assign work_addr = reg_q[IX_WADR];

  assign rdata = (addr == AW'(IX_STAT)) ? f_stat_view(stat_q, core_irq)
                                        : reg_q[addr];
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
  import dma_ctl_pkg::*;
#(
  parameter logic [31:0] WADDR_RST = 32'hFFFF_FFFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [1:0]    cmd_op,
  input logic          rd_irq_bit,
  input logic          rd_clr_mode,
  input logic          core_irq,
  input logic [SW-1:0] flag_set,
  input logic          xfer_en,
  input logic          start_pulse,
  input logic          abort_pulse,
  input logic          blast_pulse,
  input logic [SW-1:0] stat_q,
  input logic [DW-1:0] work_cnt,
  input logic [DW-1:0] start_cnt,
  input logic [DW-1:0] work_addr
);
  a_r1_reset_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (work_addr == WADDR_RST) && !xfer_en && (stat_q[5:1] == 5'd0));

  a_r3_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_pulse, abort_pulse, blast_pulse}));

  a_r3_start_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(IX_CMD) && cmd_op == 2'd3) |-> start_pulse);

  a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> xfer_en);

  a_r3_enable_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(IX_CMD) && cmd_op == 2'd0) |=> !xfer_en);

  a_r4_count_copy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> work_cnt == $past(start_cnt));

  a_r2_work_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(IX_WCNT)) |=> $stable(work_cnt));

  a_r5_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && flag_set == '0) |=> stat_q == '0);

  a_r8_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(IX_STAT) && rd_clr_mode && flag_set[3:1] == 3'd0)
      |=> stat_q[3:1] == 3'd0);

  a_r8_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(IX_STAT) && rd_clr_mode && !rd_en && flag_set == '0)
      |=> $stable(stat_q));

  a_r9_irq_view: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(IX_STAT)) |-> rd_irq_bit == core_irq);

  a_r9_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[SB_IRQ]);
endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(.WADDR_RST(WADDR_RST)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .cmd_op      (wdata[1:0]),
  .rd_irq_bit  (rdata[4]),
  .rd_clr_mode (rd_clr_mode),
  .core_irq    (core_irq),
  .flag_set    (flag_set),
  .xfer_en     (xfer_en),
  .start_pulse (start_pulse),
  .abort_pulse (abort_pulse),
  .blast_pulse (blast_pulse),
  .stat_q      (stat_q),
  .work_cnt    (work_cnt),
  .start_cnt   (start_cnt),
  .work_addr   (work_addr)
);

// File: tb/dma_ctl_regs_bench.sv
module dma_ctl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_clr_mode = 1'b0, core_irq = 1'b0;
  logic [5:0]  flag_set = '0;
  logic        xfer_en, start_pulse, abort_pulse, blast_pulse;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ctl_regs u_dma_ctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_clr_mode(rd_clr_mode),
    .core_irq(core_irq), .flag_set(flag_set), .xfer_en(xfer_en),
    .start_pulse(start_pulse), .abort_pulse(abort_pulse),
    .blast_pulse(blast_pulse)
  );

  typedef struct packed {
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // write one register, then read one register and compare
  localparam vec_t TBL [8] = '{
    '{3'd1, 32'h0000_1234, 3'd1, 32'h0000_1234},  // R2 start count
    '{3'd2, 32'hA5A5_0004, 3'd2, 32'hA5A5_0004},  // R2 start address
    '{3'd6, 32'h0BAD_F00C, 3'd6, 32'h0BAD_F00C},  // R2 start descriptor
    '{3'd0, 32'h0000_0083, 3'd3, 32'h0000_1234},  // R4 start copies count
    '{3'd3, 32'hDEAD_BEEF, 3'd3, 32'h0000_1234},  // R2 working count read-only
    '{3'd4, 32'hFFFF_0000, 3'd4, 32'hA5A5_0004},  // R2/R4 working address
    '{3'd7, 32'h0000_0000, 3'd7, 32'h0BAD_F00C},  // R2/R4 working descriptor
    '{3'd0, 32'h0000_0040, 3'd0, 32'h0000_0040}   // R2 command readback (idle)
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // command write with same-cycle pulse check
  task automatic wr_cmd_pulse(logic [31:0] d, logic [2:0] exp_sab, string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = d;
    #1;
    check(tag, {29'd0, start_pulse, abort_pulse, blast_pulse}, {29'd0, exp_sab});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b0;
    #1 v = rdata;
  endtask

  task automatic rd_strobe(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_flags(logic [5:0] f);
    @(negedge clk);
    flag_set = f;
    @(negedge clk);
    flag_set = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    peek(3'd4, v); check("R1 working address", v, 32'hFFFF_FFFF);
    peek(3'd7, v); check("R1 working descriptor", v, 32'hFFFF_FFFD);
    peek(3'd3, v); check("R1 working count low half", v & 32'h0000_FFFF, 32'h0);
    peek(3'd0, v); check("R1 command fields", v & 32'h0000_00F7, 32'h0);
    peek(3'd5, v); check("R1 status bits 5..1", v & 32'h0000_003E, 32'h0);
    check("R1 xfer_en", {31'd0, xfer_en}, 32'h0);

    // vector table (R2, R4)
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i].wa, TBL[i].wd);
      peek(TBL[i].ra, v);
      check($sformatf("R2/R4 vector %0d", i), v, TBL[i].ex);
    end

    // R3 command decode and enable
    wr_cmd_pulse(32'h0000_0002, 3'b010, "R3 abort pulse");
    wr_cmd_pulse(32'h0000_0001, 3'b001, "R3 blast pulse");
    check("R3 blast leaves xfer_en", {31'd0, xfer_en}, 32'h0);
    wr_cmd_pulse(32'h0000_0003, 3'b100, "R3 start pulse");
    check("R3 start sets xfer_en", {31'd0, xfer_en}, 32'h1);
    wr_cmd_pulse(32'h0000_0002, 3'b010, "R3 abort keeps enable pulse");
    check("R3 abort leaves xfer_en", {31'd0, xfer_en}, 32'h1);
    wr_cmd_pulse(32'h0000_0000, 3'b000, "R3 idle no pulse");
    check("R3 idle clears xfer_en", {31'd0, xfer_en}, 32'h0);

    // R6 sticky flags, flag_set[4] ignored
    pulse_flags(6'h3E);
    peek(3'd5, v); check("R6 flags set", v, 32'h0000_002E);
    repeat (3) @(negedge clk);
    peek(3'd5, v); check("R6 flags held", v, 32'h0000_002E);

    // R7 write-one-to-clear
    wr(3'd5, 32'h0000_0004);
    peek(3'd5, v); check("R7 clear abort bit", v, 32'h0000_002A);
    wr(3'd5, 32'h0000_0021);
    peek(3'd5, v); check("R7 bits 0 and 5 not cleared", v, 32'h0000_002A);
    wr(3'd5, 32'hFFFF_FFFF);
    peek(3'd5, v); check("R7 clear all clearable", v, 32'h0000_0020);

    // R9 interrupt view
    core_irq = 1'b1;
    peek(3'd5, v); check("R9 irq shown", v, 32'h0000_0030);
    core_irq = 1'b0;
    peek(3'd5, v); check("R9 irq not stored", v, 32'h0000_0020);

    // R5 start clears status
    pulse_flags(6'h01);
    peek(3'd5, v); check("R6 power-down set", v, 32'h0000_0021);
    wr(3'd0, 32'h0000_0003);
    peek(3'd5, v); check("R5 start clears status", v, 32'h0);
    wr(3'd0, 32'h0000_0000);

    // R6 set wins over write clear
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd5; wdata = 32'h0000_0008; flag_set = 6'h08;
    @(negedge clk);
    wr_en = 1'b0; flag_set = '0;
    peek(3'd5, v); check("R6 set wins over clear", v, 32'h0000_0008);

    // R8 clear-on-read mode
    rd_clr_mode = 1'b1;
    pulse_flags(6'h27);
    wr(3'd5, 32'hFFFF_FFFF);
    peek(3'd5, v); check("R8 status write ignored", v, 32'h0000_002F);
    rd_strobe(3'd5, v); check("R8 read returns value", v, 32'h0000_002F);
    peek(3'd5, v); check("R8 read clears bits 3..1", v, 32'h0000_0021);
    rd_clr_mode = 1'b0;

    // R10 retention across reset
    wr(3'd1, 32'h00AB_CDEF);
    wr(3'd0, 32'h0000_0003);
    peek(3'd3, v); check("R4 count copy", v, 32'h00AB_CDEF);
    wr(3'd0, 32'h0000_0108);
    pulse_flags(6'h01);
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    peek(3'd3, v); check("R10 working count upper half kept", v, 32'h00AB_0000);
    peek(3'd1, v); check("R10 start count kept", v, 32'h00AB_CDEF);
    peek(3'd5, v); check("R10 power-down kept", v, 32'h0000_0001);
    peek(3'd0, v); check("R10 command bits 3 and 8 kept", v, 32'h0000_0108);
    peek(3'd4, v); check("R1 working address after second reset", v, 32'hFFFF_FFFF);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule